// File: doc/BRIEF.md
# Dual-Clock FIFO with Mode-Selectable Flags

This block carries words in one direction between two clock domains. A producer writes words on the write clock; a consumer reads them on the read clock, which may have no fixed relation to the write clock. Each side has an active-low chip select and an active-high enable. A transfer happens on a rising edge only when both qualifiers are asserted. Write and read pointers cross between the domains as Gray codes through multi-flop synchronisers. Every flag is therefore pessimistic: it may report less room or fewer words than the true state, but never more.

While master reset is asserted, a timing-mode input is sampled. In standard timing, a read strobe moves the oldest word onto the read-data output on the edge that accepts the strobe. The read-side flag then means "memory not empty". In fall-through timing, the oldest word is preloaded into the output register without any strobe. The read-side flag then means "valid data is present on the output now", and a strobe consumes that word and preloads the next. Two active-low threshold flags report an almost-empty state on the read side and an almost-full state on the write side. Their offsets are fixed at elaboration and take effect from reset.

Top module: `dcf_fifo`

## Requirements
- R1: A write is accepted only on a write-clock rising edge with `wcs_n` = 0 and `wen` = 1. Any other combination leaves the stored contents and count unchanged.
- R2: `mode_std` is captured on read-clock edges while `mrst_n` = 0: 1 selects standard timing and 0 selects fall-through timing. It is ignored afterwards.
- R3: `wr_rdy` is 1 while the memory array holds fewer than 2^AW words and 0 when it is full. Writes attempted while `wr_rdy` = 0 are dropped. In fall-through mode, total capacity is 2^AW + 1 words, because the output register holds one more.
- R4: In standard mode, `rd_flag` is 1 exactly when at least one word is stored. A read strobe puts the oldest word on `rdata` after that edge, in write order.
- R5: In fall-through mode, the oldest word appears on `rdata` with `rd_flag` = 1 without any strobe. A strobe consumes it and shows the next word, or drops `rd_flag` if none remains. Without a strobe, `rdata` holds steady.
- R6: `ae_n` is 0 when the number of words held on the read side (the memory plus, in fall-through mode, the output register) is at most AE_OFS, and 1 otherwise.
- R7: `af_n` is 0 when the number of free memory locations is at most AF_OFS, and 1 otherwise.
- R8: A read strobe while `rd_flag` = 0 is ignored. The next word written is still the next word read.
- R9: `rdata_oe` is 1 exactly when `rcs_n` = 0, marking when the read data would be driven.
- R10: After master reset, both pointers are cleared: `rd_flag` = 0, `wr_rdy` = 1, `ae_n` = 0, `af_n` = 1.
- R11: Each pointer's Gray code changes by at most one bit per clock edge in its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| mode_std | input | 1 | Timing mode sampled during reset (1 standard, 0 fall-through) |
| wcs_n | input | 1 | Write-side chip select, active low |
| wen | input | 1 | Write enable, active high |
| wdata | input | DW | Write data |
| wr_rdy | output | 1 | Full flag / input-ready, high when a write can be accepted |
| af_n | output | 1 | Almost-full, active low |
| rcs_n | input | 1 | Read-side chip select, active low |
| ren | input | 1 | Read enable, active high |
| rdata | output | DW | Read data register |
| rdata_oe | output | 1 | High when the read data would be driven |
| rd_flag | output | 1 | Empty flag (standard) or output-ready (fall-through), high when data is available |
| ae_n | output | 1 | Almost-empty, active low |

## Verification
The overlap that matters is a write and a read landing in the same stretch of cycles. In that window the write side advances its pointer while the read side consumes a word, and in fall-through mode it also preloads the next one. A streaming phase provokes this: in each mode, a writer paced only by `wr_rdy` and a reader paced only by `rd_flag` run at once on clocks of 8 ns and 12 ns. The reader compares every word against an arithmetic sequence. A separate sweep fills the block to every level from empty to beyond capacity. At each level, after the synchronisers have settled, it checks all four flags against counts computed in the bench, then drains and checks the count and the order.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   typedef enum logic {
      MODE_FWFT = 1'b0,
      MODE_STD  = 1'b1
   } dcf_mode_e;
endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dcf_gray_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
   parameter int AW     = 4,
   parameter int AF_OFS = 3
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          en,
   input  logic [AW:0]   rgray_w,
   output logic [AW-1:0] waddr,
   output logic          wr_fire,
   output logic [AW:0]   wgray,
   output logic          wr_rdy,
   output logic          af_n
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
   localparam logic [PW-1:0] AF_P    = PW'(AF_OFS);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PW-1:0] wbin, wbin_nx, rbin_s, used, free;
   logic          full;

   always_comb begin
      rbin_s  = g2b(rgray_w);
      used    = wbin - rbin_s;
      free    = DEPTH_P - used;
      full    = (used == DEPTH_P);
      wr_fire = !cs_n && en && !full;
      wbin_nx = wbin + PW'(1);
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_fire) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   assign waddr  = wbin[AW-1:0];
   assign wr_rdy = !full;
   assign af_n   = !(free <= AF_P);

   assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
      (!cs_n && en && !wr_rdy) |=> $stable(wbin));
   assert_used_bound_R3: assert property (@(posedge wclk) disable iff (!rst_n)
      used <= DEPTH_P);
   assert_qualify_R1: assert property (@(posedge wclk) disable iff (!rst_n)
      (cs_n || !en) |=> $stable(wbin));
   assert_full_implies_af_R7: assert property (@(posedge wclk) disable iff (!rst_n)
      !wr_rdy |-> !af_n);
   assert_gray_step_R11: assert property (@(posedge wclk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
   import dcf_pkg::*;
#(
   parameter int AW     = 4,
   parameter int DW     = 8,
   parameter int AE_OFS = 2
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          mode_in,
   input  logic          cs_n,
   input  logic          en,
   input  logic [AW:0]   wgray_r,
   input  logic [DW-1:0] mem_q,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic [DW-1:0] dout,
   output logic          rd_flag,
   output logic          ae_n
);
   localparam int PW = AW + 1;
   localparam logic [PW:0] AE_P = (PW+1)'(AE_OFS);

   function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   dcf_mode_e     mode_q;
   logic [PW-1:0] rbin, rbin_nx, wbin_s, avail;
   logic [PW:0]   held;
   logic          ov, has, rd_req, fetch;

   always_ff @(posedge rclk) begin
      if (!rst_n) mode_q <= dcf_mode_e'(mode_in);
   end

   always_comb begin
      wbin_s  = g2b(wgray_r);
      avail   = wbin_s - rbin;
      has     = (avail != '0);
      rd_req  = !cs_n && en;
      rbin_nx = rbin + PW'(1);
      if (mode_q == MODE_STD) fetch = rd_req && has;
      else                    fetch = has && (!ov || rd_req);
      held    = {1'b0, avail} + {{PW{1'b0}}, ov};
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
         dout  <= '0;
         ov    <= 1'b0;
      end else begin
         if (fetch) begin
            dout  <= mem_q;
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
         end
         if (mode_q == MODE_FWFT) begin
            if (fetch)       ov <= 1'b1;
            else if (rd_req) ov <= 1'b0;
         end
      end
   end

   assign raddr   = rbin[AW-1:0];
   assign rd_flag = (mode_q == MODE_STD) ? has : ov;
   assign ae_n    = !(held <= AE_P);

   assert_no_underrun_R8: assert property (@(posedge rclk) disable iff (!rst_n)
      !has |=> $stable(rbin));
   assert_fwft_hold_R5: assert property (@(posedge rclk) disable iff (!rst_n)
      (mode_q == MODE_FWFT && ov && !rd_req) |=> (ov && $stable(dout)));
   assert_std_empty_ae_R6: assert property (@(posedge rclk) disable iff (!rst_n)
      (mode_q == MODE_STD && !rd_flag) |-> !ae_n);
   assert_mode_locked_R2: assert property (@(posedge rclk) disable iff (!rst_n)
      $stable(mode_q));
   assert_gray_step_R11: assert property (@(posedge rclk) disable iff (!rst_n)
      $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
   parameter int DW          = 8,
   parameter int AW          = 4,
   parameter int AE_OFS      = 2,
   parameter int AF_OFS      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          mrst_n,
   input  logic          mode_std,
   input  logic          wcs_n,
   input  logic          wen,
   input  logic [DW-1:0] wdata,
   output logic          wr_rdy,
   output logic          af_n,
   input  logic          rcs_n,
   input  logic          ren,
   output logic [DW-1:0] rdata,
   output logic          rdata_oe,
   output logic          rd_flag,
   output logic          ae_n
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   if (AW < 2 || AW > 12) begin : g_bad_aw
      $error("dcf_fifo: AW out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dcf_fifo: DW must be positive");
   end
   if (AE_OFS < 0 || AE_OFS > DEPTH) begin : g_bad_ae
      $error("dcf_fifo: AE_OFS out of range");
   end
   if (AF_OFS < 0 || AF_OFS > DEPTH) begin : g_bad_af
      $error("dcf_fifo: AF_OFS out of range");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] waddr, raddr;
   logic [PW-1:0] wgray, rgray, wgray_r, rgray_w;
   logic          wr_fire;

   always_ff @(posedge wclk) begin
      if (wr_fire) mem[waddr] <= wdata;
   end

   dcf_wr_ctrl #(.AW(AW), .AF_OFS(AF_OFS)) u_wr (
      .wclk(wclk), .rst_n(mrst_n), .cs_n(wcs_n), .en(wen),
      .rgray_w(rgray_w), .waddr(waddr), .wr_fire(wr_fire),
      .wgray(wgray), .wr_rdy(wr_rdy), .af_n(af_n)
   );

   dcf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(mrst_n), .d(wgray), .q(wgray_r)
   );

   dcf_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(mrst_n), .d(rgray), .q(rgray_w)
   );

   dcf_rd_ctrl #(.AW(AW), .DW(DW), .AE_OFS(AE_OFS)) u_rd (
      .rclk(rclk), .rst_n(mrst_n), .mode_in(mode_std), .cs_n(rcs_n),
      .en(ren), .wgray_r(wgray_r), .mem_q(mem[raddr]), .raddr(raddr),
      .rgray(rgray), .dout(rdata), .rd_flag(rd_flag), .ae_n(ae_n)
   );

   assign rdata_oe = !rcs_n;
endmodule

// File: tb/tb_dcf_fifo.sv
module tb_dcf_fifo;
   localparam int DW = 8, AW = 4, AE = 2, AF = 3;
   localparam int DEPTH = 1 << AW;

   logic wclk = 0, rclk = 0, mrst_n = 0, mode_std = 1;
   logic wcs_n = 1, wen = 0, rcs_n = 0, ren = 0;
   logic [DW-1:0] wdata = '0;
   logic wr_rdy, af_n, rdata_oe, rd_flag, ae_n;
   logic [DW-1:0] rdata;
   int total = 0, fails = 0;

   always #4 wclk = ~wclk;
   always #6 rclk = ~rclk;

   dcf_fifo #(.DW(DW), .AW(AW), .AE_OFS(AE), .AF_OFS(AF)) dut (
      .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .mode_std(mode_std),
      .wcs_n(wcs_n), .wen(wen), .wdata(wdata), .wr_rdy(wr_rdy), .af_n(af_n),
      .rcs_n(rcs_n), .ren(ren), .rdata(rdata), .rdata_oe(rdata_oe),
      .rd_flag(rd_flag), .ae_n(ae_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic std);
      mode_std = std;
      mrst_n = 0;
      wcs_n = 1; wen = 0; ren = 0; rcs_n = 0;
      repeat (4) @(posedge rclk);
      repeat (4) @(posedge wclk);
      @(negedge wclk);
      mrst_n = 1;
      mode_std = ~std;   // must be ignored after reset (R2)
   endtask

   task automatic settle();
      repeat (8) @(negedge rclk);
      repeat (8) @(negedge wclk);
      @(negedge rclk);
   endtask

   task automatic write_word(input logic [DW-1:0] v);
      @(negedge wclk); wcs_n = 0; wen = 1; wdata = v;
      @(negedge wclk); wen = 0;
   endtask

   // one read transaction; returns the word consumed
   task automatic read_word(input bit fwft, output logic [DW-1:0] v);
      if (fwft) v = rdata;
      ren = 1;
      @(negedge rclk);
      ren = 0;
      if (!fwft) v = rdata;
   endtask

   task automatic sweep(input bit fwft);
      string tag;
      logic [DW-1:0] v;
      tag = fwft ? "fwft" : "std";
      for (int n = 0; n <= DEPTH + 2; n++) begin
         int cap, acc, memu, k;
         do_reset(!fwft);
         settle();
         chk($sformatf("R10 %s rd_flag", tag), rd_flag, 0);
         chk($sformatf("R10 %s wr_rdy", tag), wr_rdy, 1);
         chk($sformatf("R10 %s ae_n", tag), ae_n, 0);
         chk($sformatf("R10 %s af_n", tag), af_n, 1);
         for (int i = 0; i < n; i++) begin
            @(negedge wclk); wcs_n = 1; wen = 1; wdata = 8'hF0; // R1 deselected
            @(negedge wclk); wcs_n = 0; wen = 0; wdata = 8'hF1; // R1 disabled
            @(negedge wclk); wen = 1; wdata = DW'(i + 1);
            @(negedge wclk); wen = 0;
         end
         settle();
         cap  = fwft ? DEPTH + 1 : DEPTH;
         acc  = (n < cap) ? n : cap;
         memu = (fwft && acc > 0) ? acc - 1 : acc;
         chk($sformatf("R4/R5 %s n=%0d rd_flag", tag, n), rd_flag, acc > 0);
         chk($sformatf("R6 %s n=%0d ae_n", tag, n), ae_n, !(acc <= AE));
         @(negedge wclk);
         chk($sformatf("R3 %s n=%0d wr_rdy", tag, n), wr_rdy, memu < DEPTH);
         chk($sformatf("R7 %s n=%0d af_n", tag, n), af_n, !((DEPTH - memu) <= AF));
         @(negedge rclk);
         if (fwft && acc > 0)
            chk($sformatf("R5 %s n=%0d preload", tag, n), rdata, 1);
         k = 0;
         while (rd_flag && k < cap + 2) begin
            read_word(fwft, v);
            chk($sformatf("R4/R5 %s n=%0d order", tag, n), v, k + 1);
            k++;
         end
         chk($sformatf("R1/R3 %s n=%0d drained", tag, n), k, acc);
         // R8: strobes while nothing available
         ren = 1; repeat (2) @(negedge rclk); ren = 0;
         chk($sformatf("R8 %s rd_flag", tag), rd_flag, 0);
         chk($sformatf("R8 %s ae_n", tag), ae_n, 0);
         write_word(8'hA5);
         settle();
         if (fwft) chk("R5 fwft preload after empty", rdata, 8'hA5);
         read_word(fwft, v);
         chk($sformatf("R8 %s next word", tag), v, 8'hA5);
      end
   endtask

   task automatic stream(input bit fwft);
      do_reset(!fwft);
      settle();
      fork
         begin
            for (int i = 0; i < 40; i++) begin
               @(negedge wclk);
               while (!wr_rdy) @(negedge wclk);
               wcs_n = 0; wen = 1; wdata = DW'((i * 7 + 3) & 8'hFF);
               @(negedge wclk); wen = 0;
            end
         end
         begin
            int j = 0;
            logic [DW-1:0] v;
            while (j < 40) begin
               @(negedge rclk);
               if (rd_flag) begin
                  read_word(fwft, v);
                  chk($sformatf("R4/R5 stream %s word %0d", fwft ? "fwft" : "std", j),
                      v, (j * 7 + 3) & 8'hFF);
                  j++;
               end
            end
         end
      join
      settle();
      chk("R4/R5 stream empty after", rd_flag, 0);
   endtask

   initial begin
      sweep(1'b0);   // R2: mode 1 at reset -> standard
      sweep(1'b1);   // R2: mode 0 at reset -> fall-through
      stream(1'b0);
      stream(1'b1);
      @(negedge rclk); rcs_n = 1;
      #1 chk("R9 oe off", rdata_oe, 0);
      rcs_n = 0;
      #1 chk("R9 oe on", rdata_oe, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(200000 * 8);
      total++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule